// File: doc/BRIEF.md
# Sign-Magnitude Add/Subtract Unit

This block adds or subtracts two signed numbers held in sign-magnitude form. Each number has a magnitude of `MAG_W` bits (default 4) and a separate sign bit, where 1 means negative. A one-cycle `start` strobe captures operand A into the accumulator, captures operand B, and records whether the magnitudes must be added or subtracted. The block then runs two fixed internal steps. In the compute step, a ripple-carry adder with XOR-controlled inversion forms A + B or A + (two's complement of B). The adder's carry out goes into a carry register. In the correct step, the same adder recomplements a negative intermediate magnitude, and the sign logic fixes the sign of the result.

When `done` pulses, the accumulator magnitude, its sign and the overflow flag hold the final result. They keep that result until the next accepted `start`. The block has no data streaming. Operands are plain inputs, sampled only in the cycle where `start` is accepted. There is no back-pressure. A `start` that arrives while an operation is running is dropped rather than held, so the caller must wait for `done` before issuing the next operation.

Top module: `smag_addsub`

## Requirements
- R1: `mode` = 0 requests A + B and `mode` = 1 requests A − B. The magnitudes are added when the effective sign relation (`mode` XOR `a_sign` XOR `b_sign`) is 0. Otherwise they are subtracted.
- R2: On the magnitude-add path, `acc_mag` is the low `MAG_W` bits of `a_mag + b_mag`, `acc_sign` equals `a_sign`, and `ovf` equals the carry out of the top magnitude bit.
- R3: On the magnitude-subtract path, `ovf` is 0.
- R4: On the subtract path with `a_mag` ≥ `b_mag`, `acc_mag` = `a_mag − b_mag` and `acc_sign` = `a_sign`. If the result is zero, `acc_sign` is forced to 0, so a negative zero never results.
- R5: On the subtract path with `a_mag` < `b_mag`, `acc_mag` = `b_mag − a_mag`, obtained by recomplementing the intermediate result, and `acc_sign` is the inverse of `a_sign`.
- R6: `done` is high for exactly one cycle. It rises at the second rising edge after the edge that accepts `start`.
- R7: While the block is idle and `start` is low, `acc_mag`, `acc_sign` and `ovf` do not change, whatever the operand inputs do.
- R8: A `start` pulse during a running operation is ignored. The result of the running operation is unaffected, and no extra `done` follows.
- R9: A synchronous active-high `rst` clears `acc_mag`, `acc_sign`, `ovf` and `done` to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; accepted only when idle |
| mode | input | 1 | 0 = add, 1 = subtract |
| a_mag | input | MAG_W | Magnitude of operand A |
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| b_mag | input | MAG_W | Magnitude of operand B |
| b_sign | input | 1 | Sign of operand B (1 = negative) |
| acc_mag | output | MAG_W | Accumulator magnitude (result) |
| acc_sign | output | 1 | Accumulator sign (result) |
| ovf | output | 1 | Magnitude overflow flag |
| done | output | 1 | One-cycle pulse when the result is final |

## Verification
The bench builds the block with its default 4-bit magnitude. At that width the whole operand space has only 2048 combinations of magnitudes, signs and mode, so several hundred seeded random operations regularly land on equal magnitudes, zero operands, negative zeros and sums that carry out. Directed cases pin down overflow to exactly zero, the forced-positive zero on both subtract routes, and a recomplement of the largest magnitude. Some operations also carry a second `start` injected mid-flight, and after each operation the operand pins are toggled while idle. These show that the result is unaffected in both situations.

// File: rtl/smas_pkg.sv
package smas_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COMPUTE = 2'd1,
    ST_CORRECT = 2'd2
  } smas_state_t;

  // High when the magnitudes must be subtracted rather than added.
  function automatic logic eff_subtract(input logic mode,
                                        input logic sign_a,
                                        input logic sign_b);
    return mode ^ sign_a ^ sign_b;
  endfunction

endpackage

// File: rtl/smas_bit_adder.sv
module smas_bit_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (x & ci) | (y & ci);

endmodule

// File: rtl/smas_ripple.sv
module smas_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         inv,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0]   carry;
  logic [W-1:0] b_eff;

  // The inversion control also serves as the carry into the low bit.
  assign carry[0] = inv;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_eff[i] = op_b[i] ^ inv;
    smas_bit_adder u_fa (
      .x  (op_a[i]),
      .y  (b_eff[i]),
      .ci (carry[i]),
      .s  (sum[i]),
      .co (carry[i+1])
    );
  end

  assign cout = carry[W];

  always_comb begin
    AST_RIPPLE_MATCH: assert ({cout, sum} ==
        ({1'b0, op_a} + {1'b0, (op_b ^ {W{inv}})} + {{W{1'b0}}, inv}))
      else $error("ripple chain disagrees with arithmetic sum"); // R2
  end

endmodule

// File: rtl/smas_sign_fix.sv
module smas_sign_fix (
  input  logic sub_path,
  input  logic carry_q,
  input  logic mag_zero,
  input  logic sign_q,
  output logic recomp,
  output logic sign_next
);

  always_comb begin
    recomp    = 1'b0;
    sign_next = sign_q;
    if (sub_path) begin
      if (!carry_q) begin
        // Intermediate result came out negative: recomplement, flip sign.
        recomp    = 1'b1;
        sign_next = ~sign_q;
      end else if (mag_zero) begin
        sign_next = 1'b0;
      end
    end
  end

endmodule

// File: rtl/smag_addsub.sv
module smag_addsub
  import smas_pkg::*;
#(
  parameter int MAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             a_sign,
  input  logic [MAG_W-1:0] b_mag,
  input  logic             b_sign,
  output logic [MAG_W-1:0] acc_mag,
  output logic             acc_sign,
  output logic             ovf,
  output logic             done
);

  localparam logic [MAG_W-1:0] MAG_ZERO = '0;

  smas_state_t      state_q;
  logic [MAG_W-1:0] acc_q, b_q;
  logic             acc_s_q, sub_q, e_q, avf_q, done_q;

  logic [MAG_W-1:0] add_a, add_b, add_sum;
  logic             add_inv, add_cout;
  logic             recomp, sign_next;

  // One adder serves both steps: A +/- B in compute, 0 - A in correct.
  always_comb begin
    if (state_q == ST_CORRECT) begin
      add_a   = MAG_ZERO;
      add_b   = acc_q;
      add_inv = 1'b1;
    end else begin
      add_a   = acc_q;
      add_b   = b_q;
      add_inv = sub_q;
    end
  end

  smas_ripple #(.W(MAG_W)) u_add (
    .op_a (add_a),
    .op_b (add_b),
    .inv  (add_inv),
    .sum  (add_sum),
    .cout (add_cout)
  );

  smas_sign_fix u_sign (
    .sub_path  (sub_q),
    .carry_q   (e_q),
    .mag_zero  (acc_q == MAG_ZERO),
    .sign_q    (acc_s_q),
    .recomp    (recomp),
    .sign_next (sign_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      b_q     <= '0;
      acc_s_q <= 1'b0;
      sub_q   <= 1'b0;
      e_q     <= 1'b0;
      avf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            acc_q   <= a_mag;
            acc_s_q <= a_sign;
            b_q     <= b_mag;
            sub_q   <= eff_subtract(mode, a_sign, b_sign);
            state_q <= ST_COMPUTE;
          end
        end
        ST_COMPUTE: begin
          acc_q   <= add_sum;
          e_q     <= add_cout;
          avf_q   <= sub_q ? 1'b0 : add_cout;
          state_q <= ST_CORRECT;
        end
        ST_CORRECT: begin
          if (recomp) acc_q <= add_sum;
          acc_s_q <= sign_next;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign acc_mag  = acc_q;
  assign acc_sign = acc_s_q;
  assign ovf      = avf_q;
  assign done     = done_q;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (acc_mag == MAG_ZERO && !acc_sign && !ovf && !done)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_CORRECT_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CORRECT) |=> (done && state_q == ST_IDLE)); // R6

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COMPUTE) |=> (state_q == ST_CORRECT)); // R8

  AST_SUB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (done && sub_q) |-> !ovf); // R3

  AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && sub_q && acc_mag == MAG_ZERO) |-> !acc_sign); // R4

  AST_ADD_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CORRECT && !sub_q) |=> ($stable(acc_sign) && $stable(acc_mag))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start) |=>
      ($stable(acc_mag) && $stable(acc_sign) && $stable(ovf))); // R7

endmodule

// File: tb/sim_smag_addsub.sv
module sim_smag_addsub;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] a_mag = '0, b_mag = '0;
  logic         a_sign = 1'b0, b_sign = 1'b0;
  logic [W-1:0] acc_mag;
  logic         acc_sign, ovf, done;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  smag_addsub #(.MAG_W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .a_mag(a_mag), .a_sign(a_sign), .b_mag(b_mag), .b_sign(b_sign),
    .acc_mag(acc_mag), .acc_sign(acc_sign), .ovf(ovf), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected {ovf, sign, magnitude} from the requirements.
  function automatic logic [W+1:0] ref_op(input logic [W-1:0] a, input logic as_,
                                           input logic [W-1:0] b, input logic bs_,
                                           input logic md);
    logic [W:0]   s;
    logic [W-1:0] m;
    logic         sg, ov;
    if ((md ^ as_ ^ bs_) == 1'b0) begin
      s  = {1'b0, a} + {1'b0, b};
      m  = s[W-1:0];
      ov = s[W];
      sg = as_;
    end else begin
      ov = 1'b0;
      if (a >= b) begin
        m  = a - b;
        sg = (m == '0) ? 1'b0 : as_;
      end else begin
        m  = b - a;
        sg = ~as_;
      end
    end
    return {ov, sg, m};
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic as_,
                        input logic [W-1:0] b, input logic bs_,
                        input logic md, input bit inject);
    logic [W+1:0] e;
    bit           sub;
    string        rtag;
    e   = ref_op(a, as_, b, bs_, md);
    sub = md ^ as_ ^ bs_;
    rtag = !sub ? "R1 R2" : ((a >= b) ? "R1 R4" : "R1 R5");
    @(negedge clk);
    a_mag = a; a_sign = as_; b_mag = b; b_sign = bs_; mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R6 done early (1)", int'(done), 0);
    if (inject) begin
      a_mag = ~a; a_sign = ~as_; b_mag = b ^ 4'h5; mode = ~md; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R6 done early (2)", int'(done), 0);
    @(negedge clk);
    check(done == 1'b1, "R6 done pulse", int'(done), 1);
    check(acc_mag == e[W-1:0], {rtag, inject ? " R8" : "", " magnitude"},
          int'(acc_mag), int'(e[W-1:0]));
    check(acc_sign == e[W], {rtag, inject ? " R8" : "", " sign"},
          int'(acc_sign), int'(e[W]));
    check(ovf == e[W+1], sub ? "R3 overflow" : "R2 overflow", int'(ovf), int'(e[W+1]));
    // Idle with toggling operand pins: result must hold, no second done.
    a_mag = $urandom; b_mag = $urandom; a_sign = $urandom; b_sign = $urandom; mode = $urandom;
    @(negedge clk);
    check(done == 1'b0, inject ? "R8 no extra done" : "R6 done width", int'(done), 0);
    @(negedge clk);
    check({ovf, acc_sign, acc_mag} == e, "R7 idle hold", int'({ovf, acc_sign, acc_mag}), int'(e));
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check({acc_mag, acc_sign, ovf, done} == '0, "R9 reset state",
          int'({acc_mag, acc_sign, ovf, done}), 0);

    // Directed corners
    run_op(4'd3, 0, 4'd9, 0, 0, 0);   // R1 plain add: 12
    run_op(4'd9, 0, 4'd8, 0, 0, 0);   // R2 overflow: 1, ovf
    run_op(4'd15, 1, 4'd1, 1, 0, 0);  // R2 overflow to zero, sign kept negative
    run_op(4'd5, 1, 4'd5, 1, 1, 0);   // R4 equal magnitudes -> +0
    run_op(4'd7, 1, 4'd7, 0, 0, 0);   // R4 add differing signs -> +0
    run_op(4'd0, 1, 4'd0, 1, 1, 0);   // R4 negative zero operands -> +0
    run_op(4'd3, 0, 4'd9, 0, 1, 0);   // R5 3-9 = -6
    run_op(4'd0, 0, 4'd15, 0, 1, 0);  // R5 largest recomplement
    run_op(4'd6, 0, 4'd2, 1, 1, 0);   // R1 subtract of negative: 8
    run_op(4'd4, 0, 4'd11, 0, 1, 1);  // R8 start injected mid-flight

    // Mid-sequence reset
    @(negedge clk);
    a_mag = 4'd9; b_mag = 4'd9; a_sign = 1; b_sign = 1; mode = 0; start = 1;
    @(negedge clk);
    start = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    check({acc_mag, acc_sign, ovf, done} == '0, "R9 reset mid-operation",
          int'({acc_mag, acc_sign, ovf, done}), 0);
    @(negedge clk);
    check(done == 1'b0, "R9 no done after reset", int'(done), 0);

    for (int i = 0; i < 600; i++) begin
      run_op(W'($urandom), 1'($urandom), W'($urandom), 1'($urandom),
             1'($urandom), ($urandom % 5) == 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule